// File: doc/BRIEF.md
# Two-Slot Frame Transmit Buffer

This block sits between a processor bus and a Fast Ethernet transmit path. Software builds whole frames in one of two on-chip slots. It picks a slot through a select register and pushes the frame in as 32-bit words through a single data address. It then records the frame's byte count for that slot and sets that slot's start bit. A drain engine reads each started slot out as a byte stream with valid/ready flow control and marks the final byte. When the final byte is accepted, the engine raises a sticky per-slot completion flag.

With two slots, software can fill one slot while the other is still being sent. A slot stays busy from its start write until its last byte leaves. While a slot is busy it cannot be re-selected, refilled, resized or restarted. When both slots finish before software looks, the completion register shows both flags together.

Top module: `txbuf_dual_slot`

## Requirements
- R1: After reset the select register, both length registers, both busy bits and the completion register read 0, and `irq` and `tx_valid` are low.
- R2: A write to offset 0 picks the slot given by bit 0 and returns the word fill pointer to word 0 of that slot. If the target slot is busy, the whole write is ignored and the select register keeps its value. Offset 0 reads back the current slot.
- R3: Each write to offset 1 stores the word at the fill pointer of the selected slot and advances the pointer. The write is ignored if that slot is busy or the pointer has reached the slot capacity (default 384 words).
- R4: Offsets 2 and 3 hold the byte lengths of slots 0 and 1. A written value above the slot capacity (default 1536 bytes) is stored as the capacity. A write while the slot is busy is ignored. The lengths read back.
- R5: Writing 1 in bit 0 to offset 4 (slot 0) or offset 5 (slot 1) starts an idle slot and sets its busy bit. That bit reads back at the same offset and clears when the slot completes.
- R6: A slot of length L sends exactly L bytes, least significant byte of each word first. `tx_last` is high on byte L-1 only. While `tx_valid` is high and `tx_ready` is low, the data and last flag hold.
- R7: Started slots are sent one at a time, in the order they were started. After each accepted last byte, `tx_valid` is low for at least one cycle.
- R8: Completion of slot s sets bit s of offset 6, and both bits may be set together. Writing 1 to a bit clears it, and a completion in the same cycle wins over the clear. `irq` is high while any bit is set.
- R9: A slot started with length 0 completes without putting any byte on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Any completion flag set |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The hardest state to reach from the ports has both slots busy at once, with software writes landing on a slot that is being sent. The drain engine claims a slot one cycle after it starts, so that overlap only lasts while a frame is stalled. The stimulus holds `tx_ready` low to freeze the engine on the first byte of one slot. It then fills and starts the other slot, and aims data, length and select writes at the frozen one. Releasing `tx_ready` then shows whether those writes left the stream untouched and whether both completion flags appear together.

// File: rtl/txb_pkg.sv
package txb_pkg;
   localparam int WORD_BYTES = 4;
   localparam int OFF_SEL    = 0;
   localparam int OFF_DATA   = 1;
   localparam int OFF_LEN0   = 2;
   localparam int OFF_GO0    = 4;
   localparam int OFF_IRQ    = 6;

   typedef enum logic {
      DR_IDLE = 1'b0,
      DR_SEND = 1'b1
   } drain_st_e;
endpackage

// File: rtl/txb_slot_ram.sv
module txb_slot_ram #(
   parameter int WORDS = 384,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [31:0]   wdata,
   input  logic [AW-1:0] raddr,
   output logic [31:0]   rdata
);
   logic [31:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/txb_regs.sv
module txb_regs
   import txb_pkg::*;
#(
   parameter int SLOT_BYTES = 1536,
   parameter int LEN_W      = 11,
   parameter int ADDR_W     = 3,
   parameter int AW         = 9,
   parameter int PTR_W      = 9
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   output logic                   irq,
   input  logic [1:0]             done,
   output logic                   sel_q,
   output logic [1:0]             busy_q,
   output logic [1:0][LEN_W-1:0]  len_q,
   output logic                   mem_we,
   output logic [AW-1:0]          mem_waddr
);
   localparam int SLOT_WORDS = (SLOT_BYTES + WORD_BYTES - 1) / WORD_BYTES;

   logic [PTR_W-1:0] wptr_q;
   logic [1:0]       status_q;
   logic             sel_wr;
   logic             data_wr;
   logic [LEN_W-1:0] len_clip;

   assign sel_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_SEL));
   assign data_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
   assign len_clip = (bus_wdata > 32'(SLOT_BYTES)) ? LEN_W'(SLOT_BYTES)
                                                   : bus_wdata[LEN_W-1:0];

   assign mem_we    = data_wr && !busy_q[sel_q] && (wptr_q < PTR_W'(SLOT_WORDS));
   assign mem_waddr = wptr_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         wptr_q <= '0;
      end else if (sel_wr) begin
         if (!busy_q[bus_wdata[0]]) begin
            sel_q  <= bus_wdata[0];
            wptr_q <= '0;
         end
      end else if (mem_we) begin
         wptr_q <= wptr_q + PTR_W'(1);
      end
   end

   for (genvar s = 0; s < 2; s++) begin : g_slot
      logic             busy_r;
      logic             stat_r;
      logic [LEN_W-1:0] len_r;
      logic             len_wr;
      logic             go_wr;
      logic             clr;

      assign len_wr = bus_wr && (bus_addr == ADDR_W'(OFF_LEN0 + s)) && !busy_r;
      assign go_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_GO0 + s)) && bus_wdata[0] && !busy_r;
      assign clr    = bus_wr && (bus_addr == ADDR_W'(OFF_IRQ)) && bus_wdata[s];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_r <= 1'b0;
            stat_r <= 1'b0;
            len_r  <= '0;
         end else begin
            if (len_wr) len_r <= len_clip;
            if (go_wr)        busy_r <= 1'b1;
            else if (done[s]) busy_r <= 1'b0;
            stat_r <= done[s] | (stat_r & ~clr);
         end
      end

      assign busy_q[s]   = busy_r;
      assign status_q[s] = stat_r;
      assign len_q[s]    = len_r;
   end

   assign irq = |status_q;

   always_comb begin
      bus_rdata = '0;
      case (int'(bus_addr))
         OFF_SEL:      bus_rdata = {31'd0, sel_q};
         OFF_DATA:     bus_rdata = 32'(wptr_q);
         OFF_LEN0:     bus_rdata = 32'(len_q[0]);
         OFF_LEN0 + 1: bus_rdata = 32'(len_q[1]);
         OFF_GO0:      bus_rdata = {31'd0, busy_q[0]};
         OFF_GO0 + 1:  bus_rdata = {31'd0, busy_q[1]};
         OFF_IRQ:      bus_rdata = {30'd0, status_q};
         default:      bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/txb_drain.sv
module txb_drain
   import txb_pkg::*;
#(
   parameter int LEN_W = 11,
   parameter int AW    = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            busy,
   input  logic [1:0][LEN_W-1:0] len,
   input  logic [31:0]           rd_word,
   output logic                  act_slot,
   output logic [AW-1:0]         rd_addr,
   output logic                  tx_valid,
   output logic [7:0]            tx_data,
   output logic                  tx_last,
   input  logic                  tx_ready,
   output logic [1:0]            done
);
   drain_st_e        st_q;
   logic             act_q;
   logic [LEN_W-1:0] bidx_q;
   logic             pick;

   // A slot is claimed the cycle after its start write, and starts arrive at
   // most one per cycle, so in idle at most one slot is waiting: start order holds.
   assign pick = busy[0] ? 1'b0 : 1'b1;

   assign act_slot = act_q;
   assign rd_addr  = AW'(bidx_q >> 2);
   assign tx_valid = (st_q == DR_SEND);
   assign tx_data  = rd_word[{bidx_q[1:0], 3'b000} +: 8];
   assign tx_last  = (bidx_q == len[act_q] - LEN_W'(1));

   always_comb begin
      done = '0;
      if (st_q == DR_IDLE && (|busy) && len[pick] == '0) done[pick] = 1'b1;
      if (st_q == DR_SEND && tx_ready && tx_last)       done[act_q] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= DR_IDLE;
         act_q  <= 1'b0;
         bidx_q <= '0;
      end else begin
         case (st_q)
            DR_IDLE: begin
               if ((|busy) && len[pick] != '0) begin
                  st_q   <= DR_SEND;
                  act_q  <= pick;
                  bidx_q <= '0;
               end
            end
            default: begin
               if (tx_ready) begin
                  if (tx_last) st_q <= DR_IDLE;
                  else         bidx_q <= bidx_q + LEN_W'(1);
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/txbuf_dual_slot.sv
module txbuf_dual_slot
   import txb_pkg::*;
#(
   parameter int SLOT_BYTES = 1536,
   parameter int LEN_W      = 11,
   parameter int ADDR_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              tx_ready
);
   localparam int SLOT_WORDS = (SLOT_BYTES + WORD_BYTES - 1) / WORD_BYTES;
   localparam int AW         = (SLOT_WORDS > 1) ? $clog2(SLOT_WORDS) : 1;
   localparam int PTR_W      = $clog2(SLOT_WORDS + 1);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must cover offsets 0..6");
   end
   if (SLOT_BYTES < WORD_BYTES) begin : g_bad_small
      $error("SLOT_BYTES must hold at least one word");
   end
   if (SLOT_BYTES >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for SLOT_BYTES");
   end

   logic                  sel_q;
   logic [1:0]            busy_q;
   logic [1:0][LEN_W-1:0] len_q;
   logic [1:0]            done;
   logic                  mem_we;
   logic [AW-1:0]         mem_waddr;
   logic [AW-1:0]         rd_addr;
   logic                  act_slot;
   logic [1:0][31:0]      slot_rdata;

   txb_regs #(
      .SLOT_BYTES(SLOT_BYTES), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .AW(AW), .PTR_W(PTR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .done(done),
      .sel_q(sel_q), .busy_q(busy_q), .len_q(len_q),
      .mem_we(mem_we), .mem_waddr(mem_waddr)
   );

   for (genvar s = 0; s < 2; s++) begin : g_ram
      txb_slot_ram #(.WORDS(SLOT_WORDS), .AW(AW)) u_ram (
         .clk(clk),
         .we(mem_we && (sel_q == 1'(s))),
         .waddr(mem_waddr),
         .wdata(bus_wdata),
         .raddr(rd_addr),
         .rdata(slot_rdata[s])
      );
   end

   txb_drain #(.LEN_W(LEN_W), .AW(AW)) u_drain (
      .clk(clk), .rst_n(rst_n), .busy(busy_q), .len(len_q),
      .rd_word(slot_rdata[act_slot]), .act_slot(act_slot), .rd_addr(rd_addr),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .tx_ready(tx_ready), .done(done)
   );
endmodule

// File: rtl/txb_checker.sv
module txb_checker #(
   parameter int SLOT_BYTES = 1536,
   parameter int ADDR_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              irq,
   input logic              tx_valid,
   input logic [7:0]        tx_data,
   input logic              tx_last,
   input logic              tx_ready,
   input logic              sel_q,
   input logic [1:0]        busy_q
);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

   p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && tx_last |=> !tx_valid);

   p_sel_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(0) && busy_q[bus_wdata[0]] |=> $stable(sel_q));

   p_len_clip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3)) |-> bus_rdata <= 32'(SLOT_BYTES));

   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[0] && !busy_q[0] |=> busy_q[0]);

   p_done0_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q[0]) |-> irq);

   p_done1_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q[1]) |-> irq);
endmodule

bind txbuf_dual_slot txb_checker #(.SLOT_BYTES(SLOT_BYTES), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
   .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
   .tx_ready(tx_ready), .sel_q(sel_q), .busy_q(busy_q)
);

// File: tb/sim_txbuf_dual_slot.sv
`timescale 1ns/1ps
module sim_txbuf_dual_slot;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_last;
   logic        tx_ready = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   txbuf_dual_slot u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
   );

   // vector: [31] slot, [30] toggle ready, [26:16] length, [7:0] seed
   localparam logic [31:0] VEC [6] = '{
      {1'b0, 1'b0, 3'b0, 11'd1,    8'd0, 8'h01},
      {1'b1, 1'b1, 3'b0, 11'd4,    8'd0, 8'h20},
      {1'b0, 1'b1, 3'b0, 11'd5,    8'd0, 8'h33},
      {1'b1, 1'b0, 3'b0, 11'd64,   8'd0, 8'h80},
      {1'b0, 1'b1, 3'b0, 11'd1536, 8'd0, 8'h05},
      {1'b1, 1'b0, 3'b0, 11'd2000, 8'd0, 8'h90}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 3'(a);
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] pat(input logic [7:0] seed, input int k);
      logic [31:0] w;
      for (int j = 0; j < 4; j++) w[8*j +: 8] = seed + 8'(4*k + j);
      return w;
   endfunction

   task automatic fill(input logic [7:0] seed, input int nwords);
      for (int k = 0; k < nwords; k++) wr(1, pat(seed, k));
   endtask

   // collects one frame (up to tx_last); bad counts bytes differing from seed+index
   task automatic collect(input bit tog, input logic [7:0] seed, output int n, output int bad);
      n = 0; bad = 0;
      for (int t = 0; t < 20000; t++) begin
         @(negedge clk);
         tx_ready = tog ? t[0] : 1'b1;
         if (tx_valid && tx_ready) begin
            if (tx_data !== seed + 8'(n)) bad++;
            n++;
            if (tx_last) break;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int n, bad, len, sent;
      bit slot, tog;
      logic [7:0] seed;
      bit saw;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(0, r); chk("R1 sel", r, 0);
      rd(2, r); chk("R1 len0", r, 0);
      rd(3, r); chk("R1 len1", r, 0);
      rd(4, r); chk("R1 busy0", r, 0);
      rd(5, r); chk("R1 busy1", r, 0);
      rd(6, r); chk("R1 status", r, 0);
      chk("R1 irq", irq, 0);
      chk("R1 tx_valid", tx_valid, 0);

      // vector table: R3 fill, R4 clip, R5 start, R6 stream, R8 status
      for (int v = 0; v < 6; v++) begin
         slot = VEC[v][31];
         tog  = VEC[v][30];
         len  = int'(VEC[v][26:16]);
         seed = VEC[v][7:0];
         sent = (len > 1536) ? 1536 : len;
         wr(0, 32'(slot));
         fill(seed, (len + 3) / 4);
         wr(2 + int'(slot), 32'(len));
         wr(4 + int'(slot), 1);
         collect(tog, seed, n, bad);
         chk("R6 byte count", 32'(n), 32'(sent));
         chk("R3 R6 byte values", 32'(bad), 0);
         @(negedge clk); tx_ready = 1'b0;
         rd(6, r); chk("R8 status bit", r, slot ? 32'd2 : 32'd1);
         rd(4 + int'(slot), r); chk("R5 busy self-clear", r, 0);
         wr(6, 3);
      end

      // both slots busy, writes to a busy slot ignored
      tx_ready = 1'b0;
      wr(0, 0);
      fill(8'h10, 2);
      wr(2, 8);
      wr(4, 1);
      rd(4, r); chk("R5 busy set", r, 1);
      wr(1, 32'hDEADBEEF);
      wr(2, 3);
      rd(2, r); chk("R4 len ignored busy", r, 8);
      wr(0, 1);
      rd(0, r); chk("R2 sel free slot", r, 1);
      wr(0, 0);
      rd(0, r); chk("R2 sel busy ignored", r, 1);
      fill(8'h40, 1);
      wr(3, 4);
      wr(5, 1);
      collect(1'b0, 8'h10, n, bad);
      chk("R7 first frame count", 32'(n), 8);
      chk("R3 R7 first frame data", 32'(bad), 0);
      collect(1'b0, 8'h40, n, bad);
      chk("R7 second frame count", 32'(n), 4);
      chk("R7 second frame data", 32'(bad), 0);
      @(negedge clk); tx_ready = 1'b0;
      rd(6, r); chk("R8 both done", r, 3);
      chk("R8 irq high", irq, 1);
      wr(6, 1);
      rd(6, r); chk("R8 clear bit0", r, 2);
      wr(6, 2);
      rd(6, r); chk("R8 clear bit1", r, 0);
      chk("R8 irq low", irq, 0);

      // reverse start order
      wr(0, 1); fill(8'h60, 1); wr(3, 4); wr(5, 1);
      wr(0, 0); fill(8'h70, 2); wr(2, 6); wr(4, 1);
      collect(1'b0, 8'h60, n, bad);
      chk("R7 slot1 first count", 32'(n), 4);
      chk("R7 slot1 first data", 32'(bad), 0);
      collect(1'b1, 8'h70, n, bad);
      chk("R7 slot0 second count", 32'(n), 6);
      chk("R7 slot0 second data", 32'(bad), 0);
      @(negedge clk); tx_ready = 1'b0;
      wr(6, 3);

      // R2 pointer reset on select write
      wr(0, 1);
      wr(1, 32'hAAAAAAAA);
      wr(1, 32'hBBBBBBBB);
      wr(0, 1);
      fill(8'h50, 1);
      wr(3, 4);
      wr(5, 1);
      collect(1'b0, 8'h50, n, bad);
      chk("R2 pointer reset count", 32'(n), 4);
      chk("R2 pointer reset data", 32'(bad), 0);
      @(negedge clk); tx_ready = 1'b0;
      wr(6, 3);

      // R9 zero length
      tx_ready = 1'b1;
      wr(0, 0);
      wr(2, 0);
      wr(4, 1);
      saw = 1'b0;
      for (int t = 0; t < 6; t++) begin
         @(negedge clk);
         if (tx_valid) saw = 1'b1;
      end
      chk("R9 no bytes", 32'(saw), 0);
      rd(6, r); chk("R9 status", r, 1);
      rd(4, r); chk("R9 busy clear", r, 0);
      wr(6, 3);

      // R4 clip on read-back
      wr(3, 5000);
      rd(3, r); chk("R4 clip", r, 1536);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule